// File: doc/BRIEF.md
# Glitch-free reference clock selector

The block picks one of two reference clocks, which may be unrelated and asynchronous to each other, and drives the chosen one onto a single clock output. A switch never produces a runt pulse or a shortened phase. When the select input changes, the active clock is allowed to finish its high phase. The output is then parked low, held quiet for a fixed number of timebase periods, and handed to the other clock starting on one of that clock's rising edges.

Each reference clock has its own gating cell. The cell brings the enable request into its clock domain through a two-flop synchroniser and applies it on a falling edge, so the gate changes state only while that clock is low. A controller runs on a free-running timebase clock and orders the switch: close the old gate, wait for its confirmed close, count the quiet gap, open the new gate, and wait for its confirmed open. If the old clock has stopped, a timeout forces its gate closed so that the switch can still complete. A busy flag reports that a switch is in progress.

Top module: `refclk_switch`

## Requirements
- R1: While busy is low, the output follows ref_a_clk cycle for cycle when pick is 0, and follows ref_b_clk when pick is 1.
- R2: During reset the output is low. After reset, the block starts from ref_a_clk. With pick at 0, busy then falls and the output follows ref_a_clk.
- R3: Every high pulse on the output is a complete high phase of the clock that produced it. The last high phase of the old clock is never cut short.
- R4: On a switch, the output stays low for at least GAP_CYC timebase periods between the last falling edge of the old clock and the first rising edge of the new clock.
- R5: With GAP_CYC = 200, a 125 MHz timebase and both references running, the time from a pick change to the first output rise from the new clock is at most 3 us. This holds whatever the frequencies of the two references, including when they differ.
- R6: Busy is high no later than four timebase periods after pick changes. It falls only once the output is running from the selected clock.
- R7: If pick changes again while a switch is in progress, the block completes the sequence and settles on the latest pick value. Busy does not fall in between.
- R8: If the old clock has stopped, its gate is forced closed after TMO_CYC timebase periods and the switch completes.
- R9: Every low pulse on the output is either a complete low phase of a reference clock or the quiet gap. The new clock is released only while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_a_clk | input | 1 | Reference clock chosen when pick is 0 |
| ref_b_clk | input | 1 | Reference clock chosen when pick is 1 |
| pick | input | 1 | Reference select, asynchronous to all clocks |
| tbase_clk | input | 1 | Free-running timebase that measures the gap and the timeout |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_out | output | 1 | Gated clock output |
| busy | output | 1 | High while a switch is in progress or pending |

## Verification
The assertions assume that a selected reference keeps toggling while its gate is open, and that a running reference has a half period well below the TMO_CYC timeout, so that a gate is forced closed only for a clock that has truly stopped. The stimulus keeps every reference half period to a few nanoseconds. It stops a reference only after the reference's own falling edge, and only while that reference is about to be switched away from. Pick changes are driven away from the timebase edges, and the references run at unrelated periods, so that every crossing into and out of a clock domain goes through its synchroniser.

// File: rtl/refsw_pkg.sv
`timescale 1ns/1ps
package refsw_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_CLOSE = 2'd1,
    ST_GAP   = 2'd2,
    ST_OPEN  = 2'd3
  } sw_state_t;

  localparam int NUM_REFS = 2;
endpackage

// File: rtl/refsw_sync.sv
`timescale 1ns/1ps
module refsw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/refsw_gate.sv
`timescale 1ns/1ps
module refsw_gate #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic kill_i,
  input  logic req_i,
  output logic en_o,
  output logic gclk_o
);
  // Local clear: block reset or forced close from the controller.
  logic lrst_n;
  assign lrst_n = rst_n & ~kill_i;

  logic req_s;
  logic en_q;

  refsw_sync #(.WIDTH(1), .STAGES(STAGES)) u_req_sync (
    .clk   (clk_i),
    .rst_n (lrst_n),
    .d     (req_i),
    .q     (req_s)
  );

  // Enable moves on the falling edge only, so the gate changes while the clock is low.
  always_ff @(negedge clk_i or negedge lrst_n) begin
    if (!lrst_n) en_q <= 1'b0;
    else         en_q <= req_s;
  end

  assign en_o   = en_q;
  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/refsw_ctrl.sv
`timescale 1ns/1ps
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int GAP_CYC = 200,
  parameter int TMO_CYC = 64,
  parameter int STAGES  = 2
) (
  input  logic                tbase_clk,
  input  logic                rst_n,
  input  logic                pick,
  input  logic [NUM_REFS-1:0] en_raw,
  output logic [NUM_REFS-1:0] req,
  output logic [NUM_REFS-1:0] kill,
  output logic                busy
);
  localparam int CNT_MAX = (GAP_CYC > TMO_CYC) ? GAP_CYC : TMO_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);

  logic                pick_s;
  logic [NUM_REFS-1:0] ack;
  sw_state_t           state;
  logic                cur;
  logic [CNT_W-1:0]    cnt;

  refsw_sync #(.WIDTH(1), .STAGES(STAGES)) u_pick_sync (
    .clk (tbase_clk), .rst_n (rst_n), .d (pick), .q (pick_s)
  );

  refsw_sync #(.WIDTH(NUM_REFS), .STAGES(STAGES)) u_ack_sync (
    .clk (tbase_clk), .rst_n (rst_n), .d (en_raw), .q (ack)
  );

  always_ff @(posedge tbase_clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OPEN;
      cur   <= 1'b0;
      req   <= NUM_REFS'(1);
      kill  <= '0;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (pick_s != cur) begin
            req[cur] <= 1'b0;
            cnt      <= '0;
            state    <= ST_CLOSE;
          end
        end
        ST_CLOSE: begin
          if (!ack[cur]) begin
            cnt   <= '0;
            state <= ST_GAP;
          end else if (cnt == TMO_LAST) begin
            kill[cur] <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == GAP_LAST) begin
            cur          <= pick_s;
            req[pick_s]  <= 1'b1;
            kill[pick_s] <= 1'b0;
            state        <= ST_OPEN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_OPEN: begin
          if (ack[cur]) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign busy = (state != ST_RUN) || (pick_s != cur);

  AST_SINGLE_REQ: assert property (@(posedge tbase_clk) disable iff (!rst_n)
    $countones(req) <= 1); // R3

  AST_GAP_BEFORE_OPEN: assert property (@(posedge tbase_clk) disable iff (!rst_n)
    (state == ST_OPEN && $past(state) == ST_GAP) |-> (ack == '0)); // R4

  AST_RUN_HAS_ACK: assert property (@(posedge tbase_clk) disable iff (!rst_n)
    (state == ST_RUN) |-> ack[cur]); // R1

  AST_KILL_FROM_CLOSE: assert property (@(posedge tbase_clk) disable iff (!rst_n)
    $rose(kill != '0) |-> ($past(state) == ST_CLOSE)); // R8
endmodule

// File: rtl/refclk_switch.sv
`timescale 1ns/1ps
module refclk_switch
  import refsw_pkg::*;
#(
  parameter int GAP_CYC = 200,
  parameter int TMO_CYC = 64,
  parameter int STAGES  = 2
) (
  input  logic ref_a_clk,
  input  logic ref_b_clk,
  input  logic pick,
  input  logic tbase_clk,
  input  logic rst_n,
  output logic clk_out,
  output logic busy
);
  logic [NUM_REFS-1:0] refs;
  logic [NUM_REFS-1:0] req;
  logic [NUM_REFS-1:0] kill;
  logic [NUM_REFS-1:0] en_raw;
  logic [NUM_REFS-1:0] gclk;

  assign refs = {ref_b_clk, ref_a_clk};

  refsw_ctrl #(.GAP_CYC(GAP_CYC), .TMO_CYC(TMO_CYC), .STAGES(STAGES)) u_ctrl (
    .tbase_clk (tbase_clk),
    .rst_n     (rst_n),
    .pick      (pick),
    .en_raw    (en_raw),
    .req       (req),
    .kill      (kill),
    .busy      (busy)
  );

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_gate
    refsw_gate #(.STAGES(STAGES)) u_gate (
      .clk_i  (refs[i]),
      .rst_n  (rst_n),
      .kill_i (kill[i]),
      .req_i  (req[i]),
      .en_o   (en_raw[i]),
      .gclk_o (gclk[i])
    );
  end

  assign clk_out = |gclk;
endmodule

// File: tb/refclk_switch_test.sv
`timescale 1ns/1ps
module refclk_switch_test;
  localparam int  GAP_CYC = 200;
  localparam int  TMO_CYC = 64;
  localparam real TB_PER  = 8.0;
  localparam real GAP_NS  = GAP_CYC * TB_PER;

  logic tbase_clk = 1'b0;
  logic ref_a_clk = 1'b0;
  logic ref_b_clk = 1'b0;
  logic rst_n = 1'b0;
  logic pick  = 1'b0;
  logic clk_out, busy;

  real ha = 5.0, hb = 7.0;
  bit  run_a = 1'b1;

  int checks = 0, errors = 0;
  int bad_hi = 0, bad_lo = 0, busy_falls = 0;
  real t_fall = 0.0, t_rise = 0.0, low_max = 0.0, first_rise = 0.0;
  bit  seen_rise = 1'b0, arm = 1'b0;

  refclk_switch #(.GAP_CYC(GAP_CYC), .TMO_CYC(TMO_CYC)) uut (
    .ref_a_clk (ref_a_clk), .ref_b_clk (ref_b_clk), .pick (pick),
    .tbase_clk (tbase_clk), .rst_n (rst_n), .clk_out (clk_out), .busy (busy)
  );

  always #(TB_PER/2) tbase_clk = ~tbase_clk;
  // A stopped reference always stops low, after a complete high phase.
  always begin #(ha); if (run_a || ref_a_clk) ref_a_clk = ~ref_a_clk; end
  always begin #(hb); ref_b_clk = ~ref_b_clk; end

  function automatic bit phase_ok(real w);
    return (w > 4.99 && w < 5.01) || (w > 6.99 && w < 7.01) || (w > 2.99 && w < 3.01);
  endfunction

  always @(posedge clk_out) begin
    real lw;
    lw = $realtime - t_fall;
    if (lw > low_max) low_max = lw;
    if (seen_rise && !(phase_ok(lw) || lw >= GAP_NS)) bad_lo++;
    if (arm) begin first_rise = $realtime; arm = 1'b0; end
    t_rise = $realtime;
    seen_rise = 1'b1;
  end

  always @(negedge clk_out) begin
    if (seen_rise && !phase_ok($realtime - t_rise)) bad_hi++;
    t_fall = $realtime;
  end

  always @(negedge busy) busy_falls++;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic follow(bit s, string tag);
    int mism = 0;
    @(negedge tbase_clk);
    #0.5;
    for (int k = 0; k < 300; k++) begin
      if (clk_out !== (s ? ref_b_clk : ref_a_clk)) mism++;
      #1;
    end
    chk(mism == 0, tag, "output vs selected reference mismatches", mism, 0);
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 3000) begin @(negedge tbase_clk); cyc++; end
  endtask

  task automatic do_switch(bit nv);
    real t0;
    int  cyc;
    @(negedge tbase_clk);
    t0 = $realtime; low_max = 0.0; arm = 1'b1;
    pick = nv;
    repeat (4) @(negedge tbase_clk);
    chk(busy == 1'b1, "R6", "busy after pick change", int'(busy), 1);
    wait_idle(cyc);
    chk(busy == 1'b0, "R6", "busy settles", int'(busy), 0);
    chk(low_max >= GAP_NS, "R4", "quiet gap ns", int'(low_max), int'(GAP_NS));
    chk(!arm && (first_rise - t0) <= 3000.0, "R5", "switch time ns",
        int'(first_rise - t0), 3000);
  endtask

  initial begin
    int cyc, falls0, lows;
    // R2: output low throughout reset
    lows = 0;
    for (int k = 0; k < 100; k++) begin #1.5; if (clk_out !== 1'b0) lows++; end
    chk(lows == 0, "R2", "output high during reset", lows, 0);
    @(negedge tbase_clk); rst_n = 1'b1;
    wait_idle(cyc);
    chk(busy == 1'b0, "R2", "busy after reset", int'(busy), 0);
    follow(1'b0, "R2");
    follow(1'b0, "R1");

    do_switch(1'b1);
    follow(1'b1, "R1");
    do_switch(1'b0);
    follow(1'b0, "R1");

    // Different frequency on ref B (R5 under unequal clocks)
    hb = 3.0;
    repeat (10) @(negedge tbase_clk);
    do_switch(1'b1);
    follow(1'b1, "R5");
    do_switch(1'b0);
    follow(1'b0, "R1");

    // R7: reselect during the quiet gap
    falls0 = busy_falls;
    @(negedge tbase_clk); pick = 1'b1;
    repeat (60) @(negedge tbase_clk);
    pick = 1'b0;
    wait_idle(cyc);
    chk(busy_falls - falls0 == 1, "R7", "busy falls during double change",
        busy_falls - falls0, 1);
    follow(1'b0, "R7");

    // R8: old clock stopped, switch must still complete
    run_a = 1'b0;
    repeat (30) @(negedge tbase_clk);
    do_switch(1'b1);
    follow(1'b1, "R8");
    run_a = 1'b1;
    repeat (30) @(negedge tbase_clk);
    do_switch(1'b0);
    follow(1'b0, "R8");

    chk(bad_hi == 0, "R3", "short or long high pulses", bad_hi, 0);
    chk(bad_lo == 0, "R9", "short low pulses", bad_lo, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule